// File: doc/BRIEF.md
# MDIO Management Register Controller

This block is a clause-22 MDIO master that software drives through six 32-bit registers on a simple write-strobe bus. Reads are combinational. Software picks an MDC speed with a divider code and sets the target PHY and register numbers. A read frame starts when the read bit of the command register is written as one. A write frame starts as a side effect of writing the data register. An indicator register reports whether a frame is running and whether the last read result is still pending. A soft-reset bit in the configuration register aborts any frame and holds the sequencer idle while it is set.

A frame is 64 MDC periods long, in this order: a preamble of 32 ones, start bits 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, two turnaround bits, and 16 data bits, most significant first. The sequencer FSM has five states. IDLE moves to PREAMBLE on an accepted start (transition "launch"). PREAMBLE moves to HEADER after bit 31 ("sync done"). HEADER moves to TURNAROUND after bit 45 ("address sent"). TURNAROUND moves to DATA after bit 47 ("bus turned"). DATA moves back to IDLE after bit 63 ("frame done"). Soft reset forces any state to IDLE ("abort"). MDIO changes only while MDC is low, and read data is sampled on the MDC rising edge.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After rst_n is released, every register reads zero, MDC is low and mdio_oe is low.
- R2: The registers are at these offsets. 0x20 is configuration: bit 31 soft reset, bits 2:0 divider code. 0x24 is command: bit 0 read. 0x28 is address: PHY address in bits 12:8, register number in bits 4:0. 0x2C is write data in bits 15:0. 0x30 is read result in bits 15:0. 0x34 is indicator: bit 0 busy, bit 2 read invalid. Unused bits and unmapped offsets read zero.
- R3: Writing 0x2C while idle starts a write frame. The frame is 32 ones, 01, 01, PHY, register, 10, then the data MSB first, 64 MDC rising edges in all, with mdio_oe high for the whole frame and MDIO changing only while MDC is low.
- R4: Writing 0x24 with bit 0 set while idle starts a read frame with opcode 10. mdio_oe is high for the first 46 bits and low for the last 18.
- R5: During a read, the 16 data bits are sampled on MDC rising edges, MSB first, and appear in the read-result register when the frame ends.
- R6: Busy is set from the clock after the start write until the end of the last bit. A frame keeps busy set for exactly 128 × H clock cycles, where H is the MDC half period.
- R7: Starting a read sets the invalid bit, and completing it clears the bit. A write frame leaves the bit unchanged.
- R8: For divider code c, the MDC half period is H = 20 + 4·c clock cycles, so MDC is never faster than one fortieth of the clock. The code is latched when a frame starts.
- R9: Writes to the command or write-data register while busy are ignored. They start no frame, and the register keeps its value.
- R10: While configuration bit 31 is set, a running frame is aborted, busy, MDC and mdio_oe are low, and no frame starts.
- R11: With no frame running, MDC and mdio_oe stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO input value |

## Verification
The embedded assertions check the following on every cycle. The bus is quiet when idle. MDIO changes only while MDC is low. Every mid-frame MDC high phase lasts at least the minimum half period. The first opcode bit matches the frame type. Busy drops after soft reset and after the final bit. Reads raise the invalid flag, and writes to the data register while busy are dropped. Some behaviours can only be shown by the bench's scenarios acting as a PHY: the exact bit sequence of whole frames, the release window on reads, the read data reaching the result register, the per-code MDC period and busy duration, and that no frame starts after ignored or reset-blocked commands.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int SEL_W      = 3;
    localparam int MIN_HALF   = 20;
    localparam int STEP_HALF  = 4;
    localparam int PHY_LSB    = 8;

    localparam int PRE_BITS   = 32;
    localparam int SOF_BITS   = 2;
    localparam int OP_BITS    = 2;
    localparam int TA_BITS    = 2;

    localparam logic [7:0] OFS_CFG   = 8'h20;
    localparam logic [7:0] OFS_CMD   = 8'h24;
    localparam logic [7:0] OFS_ADDR  = 8'h28;
    localparam logic [7:0] OFS_WDATA = 8'h2C;
    localparam logic [7:0] OFS_STAT  = 8'h30;
    localparam logic [7:0] OFS_IND   = 8'h34;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } seq_state_t;

    function automatic int half_cycles(input int code, input int min_h, input int step_h);
        return min_h + step_h * code;
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen
    import mdio_pkg::*;
#(
    parameter int SEL_BITS  = SEL_W,
    parameter int HALF_MIN  = MIN_HALF,
    parameter int HALF_STEP = STEP_HALF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                load,
    input  logic [SEL_BITS-1:0] sel,
    output logic                mdc,
    output logic                rise_stb,
    output logic                bit_end
);
    localparam int CODES    = 1 << SEL_BITS;
    localparam int MAX_HALF = HALF_MIN + HALF_STEP * (CODES - 1);
    localparam int PH_W     = $clog2(2 * MAX_HALF + 1);

    logic [PH_W-1:0] half_tab [CODES];
    logic [PH_W-1:0] half_q;
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] last_ph;
    logic [PH_W-1:0] hi_cnt_q;

    for (genvar g = 0; g < CODES; g++) begin : g_tab
        assign half_tab[g] = PH_W'(half_cycles(g, HALF_MIN, HALF_STEP));
    end

    assign last_ph = (half_q << 1) - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= PH_W'(HALF_MIN);
            ph_q   <= '0;
        end else begin
            if (load) half_q <= half_tab[sel];
            if (!run)                ph_q <= '0;
            else if (ph_q == last_ph) ph_q <= '0;
            else                     ph_q <= ph_q + 1'b1;
        end
    end

    assign mdc      = run && (ph_q >= half_q);
    assign rise_stb = run && (ph_q == half_q - 1'b1);
    assign bit_end  = run && (ph_q == last_ph);

    // checker state: length of the current MDC high phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_cnt_q <= '0;
        else if (mdc) hi_cnt_q <= hi_cnt_q + 1'b1;
        else          hi_cnt_q <= '0;
    end

    // R8: a mid-frame MDC high phase never lasts less than the minimum half period
    assert_mdc_min_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mdc) && run) |-> (hi_cnt_q >= PH_W'(HALF_MIN)));
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rise_stb,
    input  logic              bit_end,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rd_word,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int FRAME_BITS = PRE_BITS + SOF_BITS + OP_BITS + 2 * ADDR_W + TA_BITS + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int PRE_END    = PRE_BITS - 1;
    localparam int HDR_END    = PRE_BITS + SOF_BITS + OP_BITS + 2 * ADDR_W - 1;
    localparam int TA_END     = HDR_END + TA_BITS;
    localparam int LAST_BIT   = FRAME_BITS - 1;
    localparam int OP_MSB_IDX = PRE_BITS + SOF_BITS;

    seq_state_t              state_q, state_d;
    logic [IDX_W-1:0]        idx_q;
    logic [FRAME_BITS-1:0]   sh_q;
    logic                    is_rd_q;
    logic [DATA_W-1:0]       rd_q;
    logic [FRAME_BITS-1:0]   wr_frame, rd_frame;

    assign wr_frame = {{PRE_BITS{1'b1}}, 2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wr_word};
    assign rd_frame = {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phy_addr, reg_addr, {(TA_BITS + DATA_W){1'b1}}};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_rd || start_wr)                          state_d = ST_PRE;
            ST_PRE:  if (bit_end && idx_q == IDX_W'(PRE_END))           state_d = ST_HDR;
            ST_HDR:  if (bit_end && idx_q == IDX_W'(HDR_END))           state_d = ST_TA;
            ST_TA:   if (bit_end && idx_q == IDX_W'(TA_END))            state_d = ST_DATA;
            ST_DATA: if (bit_end && idx_q == IDX_W'(LAST_BIT))          state_d = ST_IDLE;
            default:                                                    state_d = ST_IDLE;
        endcase
        if (soft_rst) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            sh_q    <= '1;
            is_rd_q <= 1'b0;
            rd_q    <= '0;
        end else if (soft_rst) begin
            idx_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start_rd || start_wr) begin
                idx_q   <= '0;
                is_rd_q <= start_rd;
                sh_q    <= start_rd ? rd_frame : wr_frame;
            end
        end else begin
            if (rise_stb && state_q == ST_DATA && is_rd_q)
                rd_q <= {rd_q[DATA_W-2:0], mdio_i};
            if (bit_end) begin
                sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = busy ? sh_q[FRAME_BITS-1] : 1'b1;
        done    = (state_q == ST_DATA) && bit_end && (idx_q == IDX_W'(LAST_BIT)) && !soft_rst;
        done_rd = is_rd_q;
        rd_word = rd_q;
        unique case (state_q)
            ST_PRE, ST_HDR: mdio_oe = 1'b1;
            ST_TA, ST_DATA: mdio_oe = !is_rd_q;
            default:        mdio_oe = 1'b0;
        endcase
    end

    // R4: first opcode bit on the wire is 1 for reads and 0 for writes
    assert_opcode_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && idx_q == IDX_W'(OP_MSB_IDX)) |-> (mdio_o == is_rd_q));
endmodule

// File: rtl/mdio_reg_bank.sv
`timescale 1ns/1ps
module mdio_reg_bank
    import mdio_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int SEL_BITS = SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic                done_rd,
    input  logic [DATA_W-1:0]   rd_word,
    output logic                start_rd,
    output logic                start_wr,
    output logic [ADDR_W-1:0]   phy_addr,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [DATA_W-1:0]   wr_word,
    output logic [SEL_BITS-1:0] div_sel,
    output logic                soft_rst
);
    localparam int RST_BIT  = 31;
    localparam int BUSY_BIT = 0;
    localparam int INV_BIT  = 2;

    logic                rst_q;
    logic [SEL_BITS-1:0] sel_q;
    logic                cmd_q;
    logic [ADDR_W-1:0]   phy_q, reg_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   stat_q;
    logic                inval_q;
    logic                accept;
    logic                wr_cfg, wr_cmd, wr_addr, wr_data;

    assign wr_cfg  = bus_wr && (bus_addr == OFS_CFG);
    assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
    assign wr_addr = bus_wr && (bus_addr == OFS_ADDR);
    assign wr_data = bus_wr && (bus_addr == OFS_WDATA);
    assign accept  = !busy && !rst_q;

    assign start_rd = wr_cmd && bus_wdata[0] && accept;
    assign start_wr = wr_data && accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q   <= 1'b0;
            sel_q   <= '0;
            cmd_q   <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wdata_q <= '0;
            stat_q  <= '0;
            inval_q <= 1'b0;
        end else begin
            if (wr_cfg) begin
                rst_q <= bus_wdata[RST_BIT];
                sel_q <= bus_wdata[SEL_BITS-1:0];
            end
            if (wr_cmd && !busy)  cmd_q   <= bus_wdata[0];
            if (wr_addr) begin
                phy_q <= bus_wdata[PHY_LSB +: ADDR_W];
                reg_q <= bus_wdata[ADDR_W-1:0];
            end
            if (wr_data && !busy) wdata_q <= bus_wdata[DATA_W-1:0];
            if (start_rd)              inval_q <= 1'b1;
            else if (done && done_rd)  inval_q <= 1'b0;
            if (done && done_rd)       stat_q  <= rd_word;
        end
    end

    assign phy_addr = phy_q;
    assign reg_addr = reg_q;
    assign wr_word  = start_wr ? bus_wdata[DATA_W-1:0] : wdata_q;
    assign div_sel  = sel_q;
    assign soft_rst = rst_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CFG: begin
                bus_rdata[RST_BIT]        = rst_q;
                bus_rdata[SEL_BITS-1:0]   = sel_q;
            end
            OFS_CMD:   bus_rdata[0] = cmd_q;
            OFS_ADDR: begin
                bus_rdata[PHY_LSB +: ADDR_W] = phy_q;
                bus_rdata[ADDR_W-1:0]        = reg_q;
            end
            OFS_WDATA: bus_rdata[DATA_W-1:0] = wdata_q;
            OFS_STAT:  bus_rdata[DATA_W-1:0] = stat_q;
            OFS_IND: begin
                bus_rdata[BUSY_BIT] = busy;
                bus_rdata[INV_BIT]  = inval_q;
            end
            default:   bus_rdata = '0;
        endcase
    end

    // R7: an accepted read start marks the result invalid on the next cycle
    assert_invalid_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_rd |=> inval_q);

    // R9: a data-register write during a frame leaves the stored word alone
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy) |=> $stable(wdata_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int SEL_BITS  = SEL_W,
    parameter int HALF_MIN  = MIN_HALF,
    parameter int HALF_STEP = STEP_HALF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                busy, done, done_rd;
    logic [DATA_W-1:0]   rd_word, wr_word;
    logic                start_rd, start_wr, soft_rst;
    logic [ADDR_W-1:0]   phy_addr, reg_addr;
    logic [SEL_BITS-1:0] div_sel;
    logic                rise_stb, bit_end;

    mdio_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_BITS(SEL_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .done_rd(done_rd), .rd_word(rd_word), .start_rd(start_rd), .start_wr(start_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_word(wr_word),
        .div_sel(div_sel), .soft_rst(soft_rst)
    );

    mdio_mdc_gen #(.SEL_BITS(SEL_BITS), .HALF_MIN(HALF_MIN), .HALF_STEP(HALF_STEP)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(busy), .load(start_rd || start_wr),
        .sel(div_sel), .mdc(mdc), .rise_stb(rise_stb), .bit_end(bit_end)
    );

    mdio_frame_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start_rd(start_rd),
        .start_wr(start_wr), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_word(wr_word), .rise_stb(rise_stb), .bit_end(bit_end), .mdio_i(mdio_i),
        .busy(busy), .done(done), .done_rd(done_rd), .rd_word(rd_word),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // R11: no clock and no drive on the bus outside a frame
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R10: soft reset stops the sequencer by the next cycle
    assert_softrst_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy);

    // R6: busy drops right after the last bit
    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R3: mid-frame, MDIO changes only as MDC falls
    assert_mdio_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc)));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // PHY model state
    int          rise_cnt = 0;
    logic [63:0] cap = '0;
    logic [63:0] cap_oe = '0;
    longint      last_t = 0;
    longint      last_period = 0;
    logic [15:0] phy_rdata = '0;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        cap    = {cap[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        if (rise_cnt > 0) last_period = $time - last_t;
        last_t = $time;
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_rdata[63 - rise_cnt];
        else                                 mdio_i = 1'b0;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int half_of(input int code);
        return 20 + 4 * code;
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
    endfunction

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle(output int cnt);
        logic [31:0] v;
        cnt = 0;
        br(8'h34, v);
        while (v[0] && cnt < 20000) begin
            cnt++;
            @(negedge clk);
            br(8'h34, v);
        end
    endtask

    task automatic do_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] d, input int code);
        logic [31:0] v;
        logic [63:0] ef;
        int n;
        int h;
        h = half_of(code);
        bw(8'h20, 32'(code));
        bw(8'h28, {19'd0, p, 3'd0, r});
        phy_rdata = d;
        rise_cnt = 0;
        if (rd) bw(8'h24, 32'd1);
        else    bw(8'h2C, {16'hABCD, d});
        br(8'h34, v);
        check("R6 busy after start", 64'(v[0]), 64'd1);
        if (rd) check("R7 invalid set on read start", 64'(v[2]), 64'd1);
        else    check("R7 write leaves invalid", 64'(v[2]), 64'd0);
        wait_idle(n);
        check("R6 busy cycles", 64'(n), 64'(128 * h));
        check("R3 rising edge count", 64'(rise_cnt), 64'd64);
        check("R8 MDC period ns", 64'(last_period), 64'(2 * h * 10));
        ef = exp_frame(rd, p, r, d);
        if (rd) begin
            check("R4 read header bits", 64'(cap[63:18]), 64'(ef[63:18]));
            check("R4 read drive window", cap_oe, {{46{1'b1}}, 18'd0});
            br(8'h30, v);
            check("R5 read result", 64'(v), 64'(d));
            br(8'h34, v);
            check("R7 invalid cleared", 64'(v), 64'd0);
            bw(8'h24, 32'd0);
        end else begin
            check("R3 write frame bits", cap, ef);
            check("R3 write drive window", cap_oe, {64{1'b1}});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        int saved;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 8'h20; a <= 8'h34; a += 4) begin
            br(8'(a), v);
            check("R1 register reset value", 64'(v), 64'd0);
        end
        check("R1 mdc low", 64'(mdc), 64'd0);
        check("R1 mdio_oe low", 64'(mdio_oe), 64'd0);

        // R2 readback and field positions
        bw(8'h20, 32'h0000_00FD);
        br(8'h20, v);
        check("R2 config readback", 64'(v), 64'h5);
        bw(8'h28, 32'hFFFF_FFFF);
        br(8'h28, v);
        check("R2 address fields", 64'(v), 64'h1F1F);
        br(8'h38, v);
        check("R2 unmapped offset", 64'(v), 64'd0);
        bw(8'h20, 32'd0);

        // R11 idle: no clock over a long idle stretch
        rise_cnt = 0;
        repeat (200) @(negedge clk);
        check("R11 no MDC when idle", 64'(rise_cnt), 64'd0);

        // directed frames at both ends of the divider table
        do_frame(1'b0, 5'h00, 5'h1F, 16'h8001, 0);
        do_frame(1'b1, 5'h1F, 5'h00, 16'hA55A, 7);
        do_frame(1'b0, 5'h15, 5'h0A, 16'hFFFF, 3);
        do_frame(1'b1, 5'h01, 5'h02, 16'h0000, 1);

        // R9 writes during busy are ignored
        bw(8'h20, 32'd0);
        bw(8'h28, {19'd0, 5'h03, 3'd0, 5'h04});
        rise_cnt = 0;
        bw(8'h2C, 32'h0000_1234);
        repeat (100) @(negedge clk);
        bw(8'h2C, 32'h0000_BEEF);
        bw(8'h24, 32'd1);
        br(8'h2C, v);
        check("R9 data register kept", 64'(v), 64'h1234);
        br(8'h24, v);
        check("R9 command register kept", 64'(v), 64'd0);
        wait_idle(n);
        check("R9 frame carries first word", cap, exp_frame(1'b0, 5'h03, 5'h04, 16'h1234));
        repeat (300) @(negedge clk);
        br(8'h34, v);
        check("R9 no second frame busy", 64'(v), 64'd0);
        check("R9 no second frame edges", 64'(rise_cnt), 64'd64);

        // R10 soft reset aborts and blocks
        rise_cnt = 0;
        bw(8'h2C, 32'h0000_5555);
        repeat (300) @(negedge clk);
        bw(8'h20, 32'h8000_0000);
        @(negedge clk);
        br(8'h34, v);
        check("R10 busy cleared by soft reset", 64'(v[0]), 64'd0);
        check("R10 mdc low in soft reset", 64'(mdc), 64'd0);
        check("R10 oe low in soft reset", 64'(mdio_oe), 64'd0);
        saved = rise_cnt;
        bw(8'h2C, 32'h0000_7777);
        bw(8'h24, 32'd1);
        repeat (200) @(negedge clk);
        br(8'h34, v);
        check("R10 no start in soft reset", 64'(v), 64'd0);
        check("R10 no MDC in soft reset", 64'(rise_cnt), 64'(saved));
        bw(8'h24, 32'd0);
        bw(8'h20, 32'd0);
        repeat (50) @(negedge clk);
        br(8'h34, v);
        check("R10 release starts nothing", 64'(v), 64'd0);

        // random frames
        for (int i = 0; i < 8; i++) begin
            do_frame(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom),
                     int'($urandom % 8));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule